// File: doc/BRIEF.md
# Dual-Address DMA Operand Packer

This block sequences one dual-address DMA transfer unit at a time. It reads from a source and writes to a destination, and the two may use different operand widths (byte, 16-bit word or 32-bit long word). A hidden 32-bit holding register sits between the read side and the write side. Several narrow reads can fill it before one wide write empties it. The reverse also works: one wide read can be split into several narrow writes. The holding register cannot be reached through any port.

A controller first presents the operand sizes, the two start addresses and a byte count on the `cfg_*` inputs and pulses `cfg_load`. Each `req` pulse after that moves one unit, whose size is the wider of the two operand sizes. The block issues the required read beats on its bus master port, then the write beats, and pulses `ack` when the unit is finished. The address and remaining-count registers always show the next address and the bytes still to move. A bus error stops the sequence at once and leaves both addresses pointing at the beats that would have come next.

Top module: `dma_pack_seq`

## Requirements
- R1: After reset, `bus_valid`, `busy`, `ack`, `err`, `cfg_rej` and `done` are all low, and `src_addr_o`, `dst_addr_o` and `count_o` are zero.
- R2: The size code is 2'b00 for a byte (1 byte), 2'b01 for a word (2 bytes) and 2'b10 for a long word (4 bytes). A `cfg_load` in which either size field is 2'b11 loads nothing and sets `cfg_rej`. After such a load, `req` starts no bus beat until a later legal load.
- R3: A request of unit U bytes issues U/S read beats of source size S (`bus_we`=0, `bus_size`=source code). All of them come before U/D write beats of destination size D (`bus_we`=1, `bus_size`=destination code).
- R4: Packing is big-endian. A read operand is taken from the low S bytes of `bus_rdata`, and its upper bits are ignored. The byte read first lands in the most significant byte of the written operand. `bus_wdata` carries the operand in its low D bytes, with zeros above.
- R5: Unpacking emits the most significant part of the read operand first. Each write beat carries the next lower D bytes.
- R6: When the two sizes match, each request takes exactly one read beat and one write beat.
- R7: Each completed read beat adds S to `src_addr_o`, and each completed write beat adds D to `dst_addr_o`. During a beat, `bus_addr` is the current source address (read) or destination address (write).
- R8: After the final write beat of a request, `ack` is high for exactly one cycle. `count_o` then drops by U, clamped at zero, and `done` is high while a legal configuration is loaded, the count is zero and the block is idle.
- R9: When a beat ends with `bus_err`, the sequence stops and `err` sets and stays set until the next legal load. Neither address advances for the failed beat, the count is unchanged, and `req` starts no beat while `err` is set. Partially packed data is dropped, so a reload followed by a new request writes only newly read data.
- R10: A beat completes only in a cycle with `bus_ready` or `bus_err` high. Until then `bus_valid`, `bus_addr`, `bus_we` and `bus_size` stay steady.
- R11: A `req` while `done` is high, or before any legal load, starts no bus beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration (ignored while busy) |
| cfg_src_size | input | 2 | Source operand size code |
| cfg_dst_size | input | 2 | Destination operand size code |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Bytes to move |
| req | input | 1 | Request one unit |
| ack | output | 1 | One-cycle pulse when a unit completes |
| done | output | 1 | Loaded, idle and count exhausted |
| busy | output | 1 | A request is in progress |
| err | output | 1 | Sticky bus error flag |
| cfg_rej | output | 1 | Last load was rejected for a reserved size |
| src_addr_o | output | ADDR_W | Next source address |
| dst_addr_o | output | ADDR_W | Next destination address |
| count_o | output | CNT_W | Bytes remaining |
| bus_valid | output | 1 | Beat in progress |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_size | output | 2 | Size code of the current beat |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | 32 | Write operand, low-justified |
| bus_rdata | input | 32 | Read operand, low-justified |
| bus_ready | input | 1 | Beat completes this cycle |
| bus_err | input | 1 | Beat fails this cycle |

## Verification
The assertions watch the following on every cycle:
- the address step after each completed beat;
- that a stalled beat stays steady;
- that an errored beat leaves the addresses frozen and the bus quiet;
- the single-cycle `ack`;
- the outcome of a reserved size code.

Other behaviours can only be shown by the bench's scenarios, which compare against a byte model of source memory:
- the byte order of packed and unpacked data;
- the number and ordering of read and write beats;
- the clamped count;
- that a reload after an error does not reuse stale held bytes.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;

    localparam int HOLD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } opsize_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        opsize_e src;
        opsize_e dst;
    } sizes_t;

    function automatic logic size_legal(logic [1:0] code);
        return code != 2'b11;
    endfunction

    function automatic opsize_e wider(opsize_e a, opsize_e b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] byte_len(opsize_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [5:0] bit_len(opsize_e s);
        return {byte_len(s), 3'b000};
    endfunction

    // index of the final beat when a unit of size 'unit' is moved in parts of size 'part'
    function automatic logic [1:0] last_beat(opsize_e unit, opsize_e part);
        logic [1:0] diff;
        diff = unit - part;
        case (diff)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [HOLD_W-1:0] lane_mask(opsize_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_pack_ctl.sv
module dma_pack_ctl
    import dma_pack_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_src_size,
    input  logic [1:0]       cfg_dst_size,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             req,
    input  logic             bus_ready,
    input  logic             bus_err,
    output phase_e           phase_o,
    output sizes_t           sizes_o,
    output opsize_e          unit_o,
    output logic [1:0]       beat_o,
    output logic             load_ok_o,
    output logic             start_o,
    output logic             rd_fire_o,
    output logic             wr_fire_o,
    output logic             err_fire_o,
    output logic             ack_o,
    output logic             done_o,
    output logic             err_o,
    output logic             rej_o,
    output logic [CNT_W-1:0] count_o
);

    phase_e           phase_q;
    sizes_t           sizes_q;
    logic [1:0]       beat_q;
    logic [CNT_W-1:0] count_q;
    logic             loaded_q;
    logic             err_q;
    logic             rej_q;
    logic             ack_q;

    opsize_e          unit;
    logic [1:0]       rd_last;
    logic [1:0]       wr_last;
    logic [CNT_W-1:0] unit_bytes;
    logic             busy;
    logic             load_legal;
    logic             load_bad;

    assign busy       = (phase_q != PH_IDLE);
    assign unit       = wider(sizes_q.src, sizes_q.dst);
    assign rd_last    = last_beat(unit, sizes_q.src);
    assign wr_last    = last_beat(unit, sizes_q.dst);
    assign unit_bytes = {{(CNT_W-3){1'b0}}, byte_len(unit)};

    assign load_legal = cfg_load && !busy && size_legal(cfg_src_size) && size_legal(cfg_dst_size);
    assign load_bad   = cfg_load && !busy && !(size_legal(cfg_src_size) && size_legal(cfg_dst_size));

    assign start_o    = (phase_q == PH_IDLE) && req && !cfg_load && loaded_q && !err_q
                        && (count_q != '0);
    assign err_fire_o = busy && bus_err;
    assign rd_fire_o  = (phase_q == PH_READ)  && bus_ready && !bus_err;
    assign wr_fire_o  = (phase_q == PH_WRITE) && bus_ready && !bus_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            sizes_q  <= '{src: SZ_BYTE, dst: SZ_BYTE};
            beat_q   <= '0;
            count_q  <= '0;
            loaded_q <= 1'b0;
            err_q    <= 1'b0;
            rej_q    <= 1'b0;
            ack_q    <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (load_legal) begin
                sizes_q  <= '{src: opsize_e'(cfg_src_size), dst: opsize_e'(cfg_dst_size)};
                count_q  <= cfg_count;
                loaded_q <= 1'b1;
                err_q    <= 1'b0;
                rej_q    <= 1'b0;
            end else if (load_bad) begin
                loaded_q <= 1'b0;
                rej_q    <= 1'b1;
            end
            case (phase_q)
                PH_IDLE: begin
                    if (start_o) begin
                        phase_q <= PH_READ;
                        beat_q  <= '0;
                    end
                end
                PH_READ: begin
                    if (err_fire_o) begin
                        phase_q <= PH_IDLE;
                        err_q   <= 1'b1;
                    end else if (rd_fire_o) begin
                        if (beat_q == rd_last) begin
                            phase_q <= PH_WRITE;
                            beat_q  <= '0;
                        end else begin
                            beat_q <= beat_q + 2'd1;
                        end
                    end
                end
                PH_WRITE: begin
                    if (err_fire_o) begin
                        phase_q <= PH_IDLE;
                        err_q   <= 1'b1;
                    end else if (wr_fire_o) begin
                        if (beat_q == wr_last) begin
                            phase_q <= PH_IDLE;
                            ack_q   <= 1'b1;
                            count_q <= (count_q > unit_bytes) ? (count_q - unit_bytes) : '0;
                        end else begin
                            beat_q <= beat_q + 2'd1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o   = phase_q;
    assign sizes_o   = sizes_q;
    assign unit_o    = unit;
    assign beat_o    = beat_q;
    assign load_ok_o = load_legal;
    assign ack_o     = ack_q;
    assign done_o    = loaded_q && !busy && (count_q == '0);
    assign err_o     = err_q;
    assign rej_o     = rej_q;
    assign count_o   = count_q;

endmodule

// File: rtl/dma_pack_addr.sv
module dma_pack_addr
    import dma_pack_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  sizes_t            sizes,
    input  logic              rd_step,
    input  logic              wr_step,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    logic [ADDR_W-1:0] src_inc;
    logic [ADDR_W-1:0] dst_inc;

    assign src_inc = {{(ADDR_W-3){1'b0}}, byte_len(sizes.src)};
    assign dst_inc = {{(ADDR_W-3){1'b0}}, byte_len(sizes.dst)};

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr <= '0;
            dst_addr <= '0;
        end else if (load) begin
            src_addr <= src_init;
            dst_addr <= dst_init;
        end else begin
            if (rd_step) src_addr <= src_addr + src_inc;
            if (wr_step) dst_addr <= dst_addr + dst_inc;
        end
    end

endmodule

// File: rtl/dma_pack_hold.sv
module dma_pack_hold
    import dma_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  logic [HOLD_W-1:0] rdata,
    input  sizes_t            sizes,
    input  opsize_e           unit,
    input  logic [1:0]        wr_beat,
    output logic [HOLD_W-1:0] wdata
);

    logic [HOLD_W-1:0] hold_q;
    logic [7:0]        consumed;
    logic [7:0]        shamt;

    // reads shift in at the low end, so the first operand ends up most significant
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= (hold_q << bit_len(sizes.src)) | (rdata & lane_mask(sizes.src));
        end
    end

    // write beat k takes the k-th slice counted from the top of the unit
    always_comb begin
        consumed = {2'b00, bit_len(sizes.dst)} * ({6'b0, wr_beat} + 8'd1);
        shamt    = {2'b00, bit_len(unit)} - consumed;
        wdata    = (hold_q >> shamt) & lane_mask(sizes.dst);
    end

endmodule

// File: rtl/dma_pack_seq.sv
module dma_pack_seq
    import dma_pack_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_src_size,
    input  logic [1:0]        cfg_dst_size,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              req,
    output logic              ack,
    output logic              done,
    output logic              busy,
    output logic              err,
    output logic              cfg_rej,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [HOLD_W-1:0] bus_wdata,
    input  logic [HOLD_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err
);

    phase_e            phase;
    sizes_t            sizes;
    opsize_e           unit;
    logic [1:0]        beat;
    logic              load_ok;
    logic              start;
    logic              rd_fire;
    logic              wr_fire;
    logic              err_fire;
    logic [HOLD_W-1:0] held_wdata;

    dma_pack_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .cfg_src_size (cfg_src_size),
        .cfg_dst_size (cfg_dst_size),
        .cfg_count    (cfg_count),
        .req          (req),
        .bus_ready    (bus_ready),
        .bus_err      (bus_err),
        .phase_o      (phase),
        .sizes_o      (sizes),
        .unit_o       (unit),
        .beat_o       (beat),
        .load_ok_o    (load_ok),
        .start_o      (start),
        .rd_fire_o    (rd_fire),
        .wr_fire_o    (wr_fire),
        .err_fire_o   (err_fire),
        .ack_o        (ack),
        .done_o       (done),
        .err_o        (err),
        .rej_o        (cfg_rej),
        .count_o      (count_o)
    );

    dma_pack_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .src_init (cfg_src_addr),
        .dst_init (cfg_dst_addr),
        .sizes    (sizes),
        .rd_step  (rd_fire),
        .wr_step  (wr_fire),
        .src_addr (src_addr_o),
        .dst_addr (dst_addr_o)
    );

    dma_pack_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .clear   (start || err_fire),
        .capture (rd_fire),
        .rdata   (bus_rdata),
        .sizes   (sizes),
        .unit    (unit),
        .wr_beat (beat),
        .wdata   (held_wdata)
    );

    assign busy      = (phase != PH_IDLE);
    assign bus_valid = busy;
    assign bus_we    = (phase == PH_WRITE);
    assign bus_size  = bus_we ? sizes.dst : sizes.src;
    assign bus_addr  = bus_we ? dst_addr_o : src_addr_o;
    assign bus_wdata = bus_we ? held_wdata : '0;

endmodule

// File: rtl/dma_pack_seq_chk.sv
module dma_pack_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic [1:0]        cfg_src_size,
    input logic [1:0]        cfg_dst_size,
    input logic              busy,
    input logic              ack,
    input logic              done,
    input logic              err,
    input logic              cfg_rej,
    input logic [ADDR_W-1:0] src_addr_o,
    input logic [ADDR_W-1:0] dst_addr_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              bus_err
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    a_r7_src_step: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_we && bus_ready && !bus_err
        |=> src_addr_o == $past(src_addr_o) + (ONE << $past(bus_size)));

    a_r7_dst_step: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_we && bus_ready && !bus_err
        |=> dst_addr_o == $past(dst_addr_o) + (ONE << $past(bus_size)));

    a_r10_stall_steady: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready && !bus_err
        |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));

    a_r9_err_freeze: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_err
        |=> err && !bus_valid && $stable(src_addr_o) && $stable(dst_addr_o) && $stable(count_o));

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> !bus_valid);

    a_r2_reject: assert property (@(posedge clk) disable iff (rst)
        cfg_load && !busy && (cfg_src_size == 2'b11 || cfg_dst_size == 2'b11)
        |=> cfg_rej && !done && !busy);

    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r8_ack_idle: assert property (@(posedge clk) disable iff (rst)
        ack |-> !bus_valid);

    a_r3_size_legal: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_size != 2'b11);

endmodule

bind dma_pack_seq dma_pack_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_load     (cfg_load),
    .cfg_src_size (cfg_src_size),
    .cfg_dst_size (cfg_dst_size),
    .busy         (busy),
    .ack          (ack),
    .done         (done),
    .err          (err),
    .cfg_rej      (cfg_rej),
    .src_addr_o   (src_addr_o),
    .dst_addr_o   (dst_addr_o),
    .count_o      (count_o),
    .bus_valid    (bus_valid),
    .bus_we       (bus_we),
    .bus_size     (bus_size),
    .bus_addr     (bus_addr),
    .bus_ready    (bus_ready),
    .bus_err      (bus_err)
);

// File: tb/sim_dma_pack_seq.sv
`timescale 1ns/1ps
module sim_dma_pack_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_src_size = 2'b00;
    logic [1:0]  cfg_dst_size = 2'b00;
    logic [31:0] cfg_src_addr = '0;
    logic [31:0] cfg_dst_addr = '0;
    logic [15:0] cfg_count = '0;
    logic        req = 1'b0;
    logic        ack, done, busy, err, cfg_rej;
    logic [31:0] src_addr_o, dst_addr_o;
    logic [15:0] count_o;
    logic        bus_valid, bus_we;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic        bus_err = 1'b0;

    always #10 clk = ~clk;

    dma_pack_seq u0 (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] t_src0, t_dst0, exp_src, exp_dst;
    logic [15:0] exp_cnt;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] r = '0;
        for (int i = 0; i < (1 << sz); i++) r = (r << 8) | {24'b0, mem_byte(a + i)};
        return r;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return 1 << sz;
    endfunction

    task automatic do_load(input logic [1:0] s, input logic [1:0] d,
                           input logic [31:0] sa, input logic [31:0] da, input logic [15:0] cnt);
        @(negedge clk);
        cfg_src_size = s; cfg_dst_size = d;
        cfg_src_addr = sa; cfg_dst_addr = da; cfg_count = cnt;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        if (s != 2'b11 && d != 2'b11) begin
            t_src0 = sa; t_dst0 = da; exp_src = sa; exp_dst = da; exp_cnt = cnt;
        end
    endtask

    // one request; err_beat < 0 means no error injection
    task automatic do_req(input int err_beat, input int stall_pct, input logic [1:0] s, input logic [1:0] d,
                          output int nrd, output int nwr, output bit got_ack);
        int  beat = 0;
        bit  seen_wr = 0;
        bit  stall;
        nrd = 0; nwr = 0; got_ack = 0;
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (ack) begin got_ack = 1; break; end
            if (!bus_valid) break;
            stall = ($urandom % 100) < stall_pct;
            bus_ready = 1'b0; bus_err = 1'b0;
            if (!bus_we) begin
                chk(!seen_wr, "R3 read after write", 32'(bus_we), 32'd0);
                chk(bus_addr == exp_src, "R7 read address", bus_addr, exp_src);
                chk(bus_size == s, "R3 read size", 32'(bus_size), 32'(s));
                bus_rdata = rd_word(bus_addr, s) | (($urandom) << (8 * nbytes(s)) & ((s == 2'b10) ? 32'h0 : 32'hFFFF_FFFF));
            end else begin
                seen_wr = 1;
                chk(bus_addr == exp_dst, "R7 write address", bus_addr, exp_dst);
                chk(bus_size == d, "R3 write size", 32'(bus_size), 32'(d));
                chk(bus_wdata == rd_word(t_src0 + (bus_addr - t_dst0), d), "R4/R5 write data",
                    bus_wdata, rd_word(t_src0 + (bus_addr - t_dst0), d));
            end
            if (!stall) begin
                if (beat == err_beat) bus_err = 1'b1;
                else begin
                    bus_ready = 1'b1;
                    if (!bus_we) begin nrd++; exp_src = exp_src + nbytes(s); end
                    else begin nwr++; exp_dst = exp_dst + nbytes(d); end
                end
                beat++;
            end
            @(negedge clk);
        end
        bus_ready = 1'b0; bus_err = 1'b0;
    endtask

    task automatic quiet_check(input string what, input int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_valid) seen = 1;
        end
        chk(!seen, what, 32'(seen), 32'd0);
    endtask

    task automatic full_unit(input logic [1:0] s, input logic [1:0] d, input int stall_pct);
        int nrd, nwr, u;
        bit got;
        u = (s > d) ? nbytes(s) : nbytes(d);
        do_req(-1, stall_pct, s, d, nrd, nwr, got);
        exp_cnt = (exp_cnt > u) ? exp_cnt - 16'(u) : 16'd0;
        chk(got, "R8 ack pulse", 32'(got), 32'd1);
        chk(nrd == u / nbytes(s), "R3 read beat count", nrd, u / nbytes(s));
        chk(nwr == u / nbytes(d), "R3 write beat count", nwr, u / nbytes(d));
        @(negedge clk);
        chk(!ack, "R8 ack single cycle", 32'(ack), 32'd0);
        chk(count_o == exp_cnt, "R8 remaining count", 32'(count_o), 32'(exp_cnt));
        chk(src_addr_o == exp_src, "R7 source register", src_addr_o, exp_src);
        chk(dst_addr_o == exp_dst, "R7 destination register", dst_addr_o, exp_dst);
    endtask

    initial begin
        int nrd, nwr;
        bit got;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!bus_valid && !busy && !ack, "R1 bus idle after reset", {bus_valid, busy, ack}, 0);
        chk(!err && !cfg_rej && !done, "R1 flags low after reset", {err, cfg_rej, done}, 0);
        chk(src_addr_o == 0 && dst_addr_o == 0 && count_o == 0, "R1 registers zero", src_addr_o | dst_addr_o, 0);

        // R11 request before any load
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        quiet_check("R11 req before load", 4);

        // R2 reserved size rejected
        do_load(2'b11, 2'b00, 32'h100, 32'h200, 16'd4);
        chk(cfg_rej && !done, "R2 reserved source size rejected", {cfg_rej, done}, 2'b10);
        chk(src_addr_o == 0, "R2 nothing loaded", src_addr_o, 0);
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        quiet_check("R2 no start after reject", 4);
        do_load(2'b01, 2'b11, 32'h100, 32'h200, 16'd4);
        chk(cfg_rej, "R2 reserved destination size rejected", cfg_rej, 1);

        // R6 equal sizes: one read and one write each
        do_load(2'b10, 2'b10, 32'h0000_1000, 32'h0000_8000, 16'd8);
        chk(!cfg_rej, "R2 legal load clears reject", cfg_rej, 0);
        for (int k = 0; k < 2; k++) begin
            do_req(-1, 0, 2'b10, 2'b10, nrd, nwr, got);
            chk(nrd == 1 && nwr == 1 && got, "R6 two beats per unit", nrd + nwr, 2);
            exp_cnt = exp_cnt - 16'd4;
        end
        @(negedge clk);
        chk(done, "R8 done when count exhausted", done, 1);
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        quiet_check("R11 req while done", 4);

        // R9 error on the third byte read of a byte-to-long pack
        do_load(2'b00, 2'b10, 32'h0000_2001, 32'h0000_9000, 16'd8);
        do_req(2, 0, 2'b00, 2'b10, nrd, nwr, got);
        @(negedge clk);
        chk(err, "R9 error flag set", err, 1);
        chk(src_addr_o == 32'h2003, "R9 source holds next read address", src_addr_o, 32'h2003);
        chk(dst_addr_o == 32'h9000, "R9 destination unchanged", dst_addr_o, 32'h9000);
        chk(count_o == 16'd8, "R9 count unchanged", 32'(count_o), 8);
        chk(!got && nwr == 0, "R9 no write after error", nwr, 0);
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        quiet_check("R9 req ignored while error", 4);
        chk(err, "R9 error sticky", err, 1);
        // reload: new data must not carry stale bytes
        do_load(2'b00, 2'b10, 32'h0000_3005, 32'h0000_A000, 16'd4);
        chk(!err, "R9 legal load clears error", err, 0);
        full_unit(2'b00, 2'b10, 0);

        // R9 error during a write beat of an unpack
        do_load(2'b10, 2'b00, 32'h0000_4000, 32'h0000_B000, 16'd4);
        do_req(2, 0, 2'b10, 2'b00, nrd, nwr, got);
        @(negedge clk);
        chk(err && dst_addr_o == 32'hB001, "R9 destination at next write", dst_addr_o, 32'hB001);

        // R8 count not a multiple of the unit clamps at zero
        do_load(2'b01, 2'b00, 32'h0000_5000, 32'h0000_C000, 16'd3);
        full_unit(2'b01, 2'b00, 0);
        full_unit(2'b01, 2'b00, 0);
        chk(done && count_o == 0, "R8 count clamped to zero", 32'(count_o), 0);

        // constrained random mix with wait states (R3, R4, R5, R7, R10)
        for (int it = 0; it < 40; it++) begin
            logic [1:0] s, d;
            int u, n;
            s = 2'($urandom % 3);
            d = 2'($urandom % 3);
            u = (s > d) ? nbytes(s) : nbytes(d);
            n = 1 + ($urandom % 3);
            do_load(s, d, ($urandom & 32'h0FFF_FFFC), ($urandom & 32'h0FFF_FFFC), 16'(u * n));
            for (int k = 0; k < n; k++) full_unit(s, d, 35);
            chk(done, "R8 done after random transfer", done, 1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule